// File: doc/BRIEF.md
# Reset Sequencer with Strap Sampling

This block produces the internal system reset of a chip from two sources: an active-low reset pin and a request from an internal watchdog. Everything runs on the slow clock. A low level on the pin forces the internal reset at once, without waiting for a clock edge. Release of the internal reset waits for a two-flop synchronizer, so it always lines up with the slow clock.

While the pin is held low, the block records two configuration straps on every slow-clock edge. One strap selects the boot memory width and the other, which is active low, enables tri-state mode. A strap value counts only if it stayed constant over the last ten samples before the pin rose. Any other case falls back to a safe default. The accepted values are latched on the first clock edge after the pin rises and then held until the next pin reset.

A watchdog request causes a fixed-length internal reset. It leaves the latched straps untouched. It also sets a cause flag, which a later pin reset clears.

Top module: `reset_strap_seq`

## Requirements
- R1: `sys_rst_no` goes low as soon as `rst_ni` is low, without waiting for a clock edge.
- R2: After `rst_ni` rises, `sys_rst_no` stays low through the first rising edge of `clk_i` and goes high on the second one.
- R3: If `strap_boot_i` was 1 at all of the last 10 clock edges with `rst_ni` low, `boot_8bit_o` becomes 1 (8-bit boot). If it was 0 at all of them, `boot_8bit_o` becomes 0 (16-bit boot).
- R4: If `strap_tri_i` was 0 at all of the last 10 sampled edges, `tri_en_o` becomes 1. If it was 1 at all of them, `tri_en_o` becomes 0.
- R5: If a strap changes anywhere within the last 10 sampled edges, its default is used: `boot_8bit_o`=1 and `tri_en_o`=0. A change at an earlier sample has no effect.
- R6: If `rst_ni` was low for fewer than 10 clock edges, both straps take their defaults.
- R7: The strap outputs are updated on the first rising edge after `rst_ni` rises. They then hold their value while the strap pins toggle, until the next pin reset.
- R8: A one-cycle watchdog request sampled high while the block is running pulls `sys_rst_no` low after that edge for exactly 10 clock cycles. It sets `cause_wdog_o` to 1 and leaves the strap outputs unchanged.
- R9: A pin reset clears `cause_wdog_o` to 0, and the pin reset has priority. A watchdog request during a pin reset, or before its release has passed the synchronizer, is ignored.
- R10: A watchdog request that arrives while a watchdog reset is already in progress is ignored. It does not extend the 10-cycle hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slow clock |
| rst_ni | input | 1 | External reset pin, active low |
| wdog_req_i | input | 1 | Watchdog reset request |
| strap_boot_i | input | 1 | Boot width strap (1 = 8-bit) |
| strap_tri_i | input | 1 | Tri-state strap, active low |
| sys_rst_no | output | 1 | Internal system reset, active low |
| boot_8bit_o | output | 1 | Latched boot width, 1 = 8-bit |
| tri_en_o | output | 1 | Latched tri-state enable |
| cause_wdog_o | output | 1 | Last reset came from the watchdog |

## Verification
The pin reset is swept over several low durations: below the window, exactly the window, and beyond it. For each duration, the strap patterns are constant-high, constant-low, and a single toggled sample placed at every position in turn. These patterns separate a correct window edge from an off-by-one, and a qualified value from a default. Watchdog requests are applied while the block is running, while a watchdog reset is already in progress, during a pin reset, and in the synchronizer gap. Together they cover hold length, the no-extension rule, cause tracking and pin priority. The strap pins are flipped right after release and again during operation, which shows that the latch is taken only at release.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  localparam int unsigned RSQ_WIN     = 10;  // strap qualification window
  localparam int unsigned RSQ_HOLD    = 10;  // watchdog reset length
  localparam int unsigned RSQ_SYNC    = 2;   // release synchronizer depth
  localparam int unsigned RSQ_NSTRAP  = 2;

  typedef enum int unsigned {
    STRAP_BOOT = 0,
    STRAP_TRI  = 1
  } strap_idx_e;
endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rel_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rel_o = sync_q[STAGES-1];

  // release only after the pin has been high at a previous edge
  assert_sync_delay_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rel_o) |-> $past(rst_ni));
endmodule

// File: rtl/rsq_window.sv
module rsq_window #(
  parameter int unsigned WIN = 10
) (
  input  logic clk_i,
  input  logic pin_i,
  output logic sample_o,
  output logic commit_o,
  output logic full_o
);
  localparam int unsigned CW = $clog2(WIN + 1);

  logic          low_q;
  logic [CW-1:0] fill_q;

  // no reset: these flops must keep counting while the pin is low
  always_ff @(posedge clk_i) begin
    low_q <= !pin_i;
    if (!pin_i) begin
      if (!low_q)                  fill_q <= CW'(1);
      else if (fill_q < CW'(WIN))  fill_q <= fill_q + 1'b1;
    end
  end

  assign sample_o = !pin_i;
  assign commit_o = pin_i && low_q;
  assign full_o   = (fill_q >= CW'(WIN));

  // commit fires once per release
  assert_commit_once_R7: assert property (@(posedge clk_i)
    commit_o |=> !commit_o);
endmodule

// File: rtl/rsq_strap_filter.sv
module rsq_strap_filter #(
  parameter int unsigned WIN  = 10,
  parameter logic        DFLT = 1'b1
) (
  input  logic clk_i,
  input  logic sample_i,
  input  logic commit_i,
  input  logic full_i,
  input  logic d_i,
  output logic q_o
);
  logic [WIN-1:0] hist_q;
  logic           lvl_q;
  logic           decided;

  always_comb begin
    decided = DFLT;
    if (full_i) begin
      if (&hist_q)       decided = 1'b1;
      else if (~|hist_q) decided = 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (sample_i) hist_q <= {hist_q[WIN-2:0], d_i};
    if (commit_i) lvl_q  <= decided;
  end

  assign q_o = lvl_q;

  assert_strap_hold_R7: assert property (@(posedge clk_i)
    !commit_i |=> $stable(q_o));
endmodule

// File: rtl/rsq_wdog_hold.sv
module rsq_wdog_hold #(
  parameter int unsigned HOLD = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic armed_i,
  input  logic req_i,
  output logic hold_o,
  output logic fire_o
);
  localparam int unsigned CW = $clog2(HOLD + 1);

  logic [CW-1:0] cnt_q;

  assign hold_o = (cnt_q != '0);
  assign fire_o = armed_i && req_i && !hold_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (fire_o) cnt_q <= CW'(HOLD);
    else if (hold_o) cnt_q <= cnt_q - 1'b1;
  end

  // a running hold only counts down, never reloads
  assert_hold_nextend_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |=> (cnt_q == CW'($past(cnt_q) - 1'b1)));
endmodule

// File: rtl/reset_strap_seq.sv
module reset_strap_seq
  import rsq_pkg::*;
#(
  parameter int unsigned WIN  = RSQ_WIN,
  parameter int unsigned HOLD = RSQ_HOLD,
  parameter int unsigned SYNC = RSQ_SYNC
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wdog_req_i,
  input  logic strap_boot_i,
  input  logic strap_tri_i,
  output logic sys_rst_no,
  output logic boot_8bit_o,
  output logic tri_en_o,
  output logic cause_wdog_o
);
  localparam int unsigned NS = RSQ_NSTRAP;

  logic          pin_rel;
  logic          wd_hold, wd_fire;
  logic          sample, commit, full;
  logic [NS-1:0] strap_d, strap_lvl;
  logic          cause_q;

  rsq_sync #(.STAGES(SYNC)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rel_o  (pin_rel)
  );

  rsq_wdog_hold #(.HOLD(HOLD)) u_wdog (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .armed_i (pin_rel),
    .req_i   (wdog_req_i),
    .hold_o  (wd_hold),
    .fire_o  (wd_fire)
  );

  rsq_window #(.WIN(WIN)) u_win (
    .clk_i    (clk_i),
    .pin_i    (rst_ni),
    .sample_o (sample),
    .commit_o (commit),
    .full_o   (full)
  );

  assign strap_d[STRAP_BOOT] = strap_boot_i;
  assign strap_d[STRAP_TRI]  = strap_tri_i;

  for (genvar g = 0; g < NS; g++) begin : g_strap
    rsq_strap_filter #(.WIN(WIN), .DFLT(1'b1)) u_flt (
      .clk_i    (clk_i),
      .sample_i (sample),
      .commit_i (commit),
      .full_i   (full),
      .d_i      (strap_d[g]),
      .q_o      (strap_lvl[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cause_q <= 1'b0;
    else if (wd_fire) cause_q <= 1'b1;
  end

  assign sys_rst_no   = pin_rel && !wd_hold;
  assign boot_8bit_o  = strap_lvl[STRAP_BOOT];
  assign tri_en_o     = !strap_lvl[STRAP_TRI];
  assign cause_wdog_o = cause_q;

  assert_async_low_R1: assert property (@(posedge clk_i)
    !rst_ni |-> !sys_rst_no);

  // reset falling while the pin is released must be a watchdog reset
  assert_wd_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_rel && $past(pin_rel) && $fell(sys_rst_no)) |-> cause_wdog_o);

  assert_pin_priority_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_rel |-> !cause_wdog_o);
endmodule

// File: tb/reset_strap_seq_tb_top.sv
module reset_strap_seq_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wdog_req = 1'b0;
  logic strap_boot = 1'b1;
  logic strap_tri = 1'b1;
  logic sys_rst_n, boot_8bit, tri_en, cause_wdog;

  int total = 0;
  int bad = 0;
  logic exp_boot, exp_tri;

  always #2 clk = ~clk;

  reset_strap_seq dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .wdog_req_i   (wdog_req),
    .strap_boot_i (strap_boot),
    .strap_tri_i  (strap_tri),
    .sys_rst_no   (sys_rst_n),
    .boot_8bit_o  (boot_8bit),
    .tri_en_o     (tri_en),
    .cause_wdog_o (cause_wdog)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // level accepted for a strap from the last 10 samples, default 1
  function automatic logic qual(input int n, input logic [31:0] pat);
    logic [9:0] w;
    if (n < 10) return 1'b1;
    w = pat[n-10 +: 10];
    if (&w) return 1'b1;
    if (~|w) return 1'b0;
    return 1'b1;
  endfunction

  task automatic pin_reset(input int n, input logic [31:0] bp, input logic [31:0] tp,
                           input logic wd, input string req);
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check("R1 async low", sys_rst_n, 0);
    for (int i = 0; i < n; i++) begin
      strap_boot = bp[i];
      strap_tri  = tp[i];
      wdog_req   = wd;
      @(negedge clk);
    end
    rst_ni     = 1'b1;
    strap_boot = ~strap_boot;
    strap_tri  = ~strap_tri;
    wdog_req   = wd;
    exp_boot   = qual(n, bp);
    exp_tri    = !qual(n, tp);
    @(negedge clk);
    wdog_req = 1'b0;
    check("R2 low after first edge", sys_rst_n, 0);
    check({req, " boot"}, boot_8bit, exp_boot);
    check({req, " tri"}, tri_en, exp_tri);
    @(negedge clk);
    check("R2 high after second edge", sys_rst_n, 1);
    check("R9 cause cleared", cause_wdog, 0);
    check("R7 boot held", boot_8bit, exp_boot);
    check("R7 tri held", tri_en, exp_tri);
  endtask

  task automatic wd_pulse(input int extra);
    int lowcnt = 0;
    @(negedge clk);
    wdog_req = 1'b1;
    @(negedge clk);
    wdog_req = 1'b0;
    check("R8 cause set", cause_wdog, 1);
    for (int k = 0; k < 40; k++) begin
      if (sys_rst_n) break;
      lowcnt++;
      wdog_req = (lowcnt == extra);
      @(negedge clk);
    end
    wdog_req = 1'b0;
    check(extra > 0 ? "R10 hold not extended" : "R8 hold length", lowcnt, 10);
    check("R8 boot kept", boot_8bit, exp_boot);
    check("R8 tri kept", tri_en, exp_tri);
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1;
    check("R1 reset state", sys_rst_n, 0);
    pin_reset(12, '1, '1, 1'b0, "R3 R4 all high");
    pin_reset(12, '0, '0, 1'b0, "R3 R4 all low");
    pin_reset(10, '0, '0, 1'b0, "R3 R4 exact window");
    pin_reset(9,  '0, '0, 1'b0, "R6 short reset");
    pin_reset(11, 32'h1, 32'h1, 1'b0, "R5 early change");
    pin_reset(11, 32'h2, 32'h4, 1'b0, "R5 window change");
    for (int pos = 0; pos < 14; pos++) begin
      pin_reset(14, 32'h1 << pos, 32'h1 << pos, 1'b0, "R5 sweep");
    end
    for (int pos = 0; pos < 14; pos++) begin
      pin_reset(14, ~(32'h1 << pos), ~(32'h1 << pos), 1'b0, "R5 sweep inv");
    end
    // distinct from defaults, then exercise the watchdog
    pin_reset(12, '0, '0, 1'b0, "R3 R4 before watchdog");
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      strap_boot = i[0];
      strap_tri  = ~i[0];
    end
    @(negedge clk);
    check("R7 boot ignores pins", boot_8bit, 0);
    check("R7 tri ignores pins", tri_en, 1);
    wd_pulse(0);
    wd_pulse(4);
    pin_reset(12, '1, '0, 1'b1, "R9 watchdog during pin reset");
    pin_reset(13, '0, '1, 1'b0, "R9 after pin reset");
    check("R9 cause pin", cause_wdog, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule